// File: doc/BRIEF.md
# Power-Event RAM Retention Controller

This block owns three small on-chip memories (a fast bank, a large bank and a retention bank) and decides, at each power event, which of them keep their contents and which are wiped. Events are a power-on reset, entry into deep standby, and exit from deep standby. An exit carries a cause: reset, interrupt or wake pin. The decision depends on software-set enable and write-enable bits, on a retention-keep bit, on the kind of event and, for exits, on the cause.

A wiped bank is filled with a fixed poison word, one word per clock in each bank at once. A sweep always lasts as many cycles as the deepest bank has words. While the sweep runs, the control bits stay frozen and the data port is closed. After a power-on reset or a standby exit, the control bits drop to zero once the sweep ends. A status register records which banks survived the most recent event. Software reaches the banks through one shared read/write port with a bank select, and reaches the control and status words through a small register port.

Top module: `ram_retention_ctrl`

## Requirements
- R1: On a power-on reset outside deep standby, the fast bank is wiped exactly when both of its bits are set: fast enable (control bit 0) and fast write enable (control bit 1).
- R2: On a power-on reset outside deep standby, the large bank is wiped exactly when both of its bits are set: large enable (bit 2) and large write enable (bit 3).
- R3: On a power-on reset outside deep standby, the retention bank is wiped exactly when three bits are all set: large enable, large write enable and retention write enable (bit 4).
- R4: Entering deep standby always wipes the fast and large banks. It wipes the retention bank unless retention keep (bit 5) is set.
- R5: An exit with cause code 1 (interrupt) or code 2 (wake pin) leaves the retention bank as it was. An exit with cause code 0 (reset), or a power-on reset pulse while in standby, wipes the retention bank. Every exit and every power-on reset returns the control word to zero.
- R6: A wipe writes the word 0xA5 to every word of each affected bank. The busy flag (status bit 3) stays high for exactly 16 cycles per event.
- R7: The control word holds its value while busy. Register writes made while busy are ignored. The control word becomes zero at the end of a sweep that follows a power-on reset or an exit.
- R8: A read needs the bank's enable bit; the retention bank uses large enable. A write also needs the write-enable bit; the retention bank needs large enable, large write enable and retention write enable. A refused read returns zero. A refused write leaves memory unchanged. Read data appear one cycle after the request.
- R9: While busy or in deep standby (status bit 4), every access is refused: reads return zero and writes have no effect.
- R10: The register port is at address 0 for the control word and address 1 for status. Status bits 2:0 hold the retained flags for the retention, large and fast banks (1 = kept) from the most recent event. Register reads return data one cycle after the address is presented. After reset, both words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = status |
| reg_wdata | input | 6 | Register write data |
| reg_rdata | output | 6 | Registered register read data |
| por_evt | input | 1 | Power-on reset event pulse |
| dstby_enter | input | 1 | Deep standby entry pulse |
| dstby_exit | input | 1 | Deep standby exit pulse |
| wake_cause | input | 2 | Exit cause: 0 reset, 1 interrupt, 2 wake pin |
| acc_en | input | 1 | Data access request |
| acc_we | input | 1 | Access is a write |
| acc_bank | input | 2 | 0 fast, 1 large, 2 retention |
| acc_addr | input | 4 | Word address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, one cycle after request |

## Verification
The power-on reset case is swept across all 32 settings of the five enable bits. Each bank has its own rule, so the sweep shows any bank that follows the wrong combination. The standby case crosses both keep settings with each exit cause, and adds a reset pulse during standby; this separates a retention loss at entry from one at exit. Further directed patterns set the enable bits one at a time against reads and writes in each bank, and issue accesses and register writes during a sweep and during standby. This shows that each gate is separate and that the frozen control word is the one the decision used.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int NBANK = 3;
  localparam int BK_FAST = 0;
  localparam int BK_LARGE = 1;
  localparam int BK_RET = 2;

  typedef enum logic [1:0] {
    CAUSE_RESET = 2'd0,
    CAUSE_IRQ   = 2'd1,
    CAUSE_PIN   = 2'd2
  } wake_cause_e;

  typedef enum logic [2:0] {
    EV_NONE      = 3'd0,
    EV_POR       = 3'd1,
    EV_ENTER     = 3'd2,
    EV_EXIT_RST  = 3'd3,
    EV_EXIT_WAKE = 3'd4
  } pwr_evt_e;

  // control word: bit0 fast_en ... bit5 ret_keep
  typedef struct packed {
    logic ret_keep;
    logic ret_we;
    logic large_we;
    logic large_en;
    logic fast_we;
    logic fast_en;
  } ctrl_t;
endpackage

// File: rtl/rr_policy.sv
module rr_policy
  import rr_pkg::*;
(
  input  ctrl_t          ctrl,
  input  logic           por_evt,
  input  logic           dstby_enter,
  input  logic           dstby_exit,
  input  logic [1:0]     wake_cause,
  input  logic           in_standby,
  input  logic           busy,
  input  logic           ret_was_kept,
  output logic           evt_valid,
  output pwr_evt_e       evt_code,
  output logic [NBANK-1:0] clr_mask,
  output logic [NBANK-1:0] keep_flags,
  output logic           ctl_reset
);
  logic large_wr;

  always_comb begin
    evt_code = EV_NONE;
    if (!busy) begin
      if (por_evt)
        evt_code = in_standby ? EV_EXIT_RST : EV_POR;
      else if (dstby_exit && in_standby)
        evt_code = (wake_cause == CAUSE_RESET) ? EV_EXIT_RST : EV_EXIT_WAKE;
      else if (dstby_enter && !in_standby)
        evt_code = EV_ENTER;
    end
  end

  assign evt_valid = (evt_code != EV_NONE);
  assign large_wr  = ctrl.large_en & ctrl.large_we;

  always_comb begin
    clr_mask   = '0;
    keep_flags = '1;
    ctl_reset  = 1'b0;
    unique case (evt_code)
      EV_POR: begin
        clr_mask[BK_FAST]  = ctrl.fast_en & ctrl.fast_we;
        clr_mask[BK_LARGE] = large_wr;
        clr_mask[BK_RET]   = large_wr & ctrl.ret_we;
        keep_flags         = ~clr_mask;
        ctl_reset          = 1'b1;
      end
      EV_ENTER: begin
        clr_mask[BK_FAST]  = 1'b1;
        clr_mask[BK_LARGE] = 1'b1;
        clr_mask[BK_RET]   = ~ctrl.ret_keep;
        keep_flags         = ~clr_mask;
      end
      EV_EXIT_RST: begin
        clr_mask[BK_RET] = 1'b1;
        keep_flags       = '0;
        ctl_reset        = 1'b1;
      end
      EV_EXIT_WAKE: begin
        keep_flags         = '0;
        keep_flags[BK_RET] = ret_was_kept;
        ctl_reset          = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rr_clear_seq.sv
module rr_clear_seq
  import rr_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NBANK-1:0] mask_in,
  output logic             busy,
  output logic [CW-1:0]    cnt,
  output logic [NBANK-1:0] mask,
  output logic             done
);
  localparam logic [CW-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      mask <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
      mask <= mask_in;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        mask <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign done = busy && (cnt == LAST);

  p_sweep_step_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1));
  p_sweep_end_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == LAST) |=> !busy);
endmodule

// File: rtl/rr_ram_bank.sv
module rr_ram_bank #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/ram_retention_ctrl.sv
module ram_retention_ctrl
  import rr_pkg::*;
#(
  parameter int DW       = 8,
  parameter int FAST_AW  = 3,
  parameter int LARGE_AW = 4,
  parameter int RET_AW   = 2,
  parameter int POISON   = 'hA5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic                 reg_addr,
  input  logic [5:0]           reg_wdata,
  output logic [5:0]           reg_rdata,
  input  logic                 por_evt,
  input  logic                 dstby_enter,
  input  logic                 dstby_exit,
  input  logic [1:0]           wake_cause,
  input  logic                 acc_en,
  input  logic                 acc_we,
  input  logic [1:0]           acc_bank,
  input  logic [((FAST_AW > LARGE_AW ? FAST_AW : LARGE_AW) > RET_AW ?
                 (FAST_AW > LARGE_AW ? FAST_AW : LARGE_AW) : RET_AW)-1:0] acc_addr,
  input  logic [DW-1:0]        acc_wdata,
  output logic [DW-1:0]        acc_rdata
);
  localparam int AW01   = (FAST_AW > LARGE_AW) ? FAST_AW : LARGE_AW;
  localparam int MAX_AW = (AW01 > RET_AW) ? AW01 : RET_AW;
  localparam logic [DW-1:0] POISON_W = DW'(POISON);

  ctrl_t              ctrl_q;
  logic [NBANK-1:0]   status_q;
  logic               standby_q;
  logic               pend_q;

  logic               evt_valid;
  pwr_evt_e           evt_code;
  logic [NBANK-1:0]   clr_mask;
  logic [NBANK-1:0]   keep_flags;
  logic               ctl_rst;

  logic               seq_busy;
  logic [MAX_AW-1:0]  seq_cnt;
  logic [NBANK-1:0]   seq_mask;
  logic               seq_done;

  logic               open;
  logic [NBANK-1:0]   rd_perm;
  logic [NBANK-1:0]   wr_perm;
  logic [NBANK-1:0]   wr_ok;
  logic               rd_ok;
  logic               rd_ok_q;
  logic [1:0]         sel_q;
  logic [DW-1:0]      bank_q [NBANK];

  rr_policy u_policy (
    .ctrl        (ctrl_q),
    .por_evt     (por_evt),
    .dstby_enter (dstby_enter),
    .dstby_exit  (dstby_exit),
    .wake_cause  (wake_cause),
    .in_standby  (standby_q),
    .busy        (seq_busy),
    .ret_was_kept(status_q[BK_RET]),
    .evt_valid   (evt_valid),
    .evt_code    (evt_code),
    .clr_mask    (clr_mask),
    .keep_flags  (keep_flags),
    .ctl_reset   (ctl_rst)
  );

  rr_clear_seq #(.CW(MAX_AW)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (evt_valid),
    .mask_in (clr_mask),
    .busy    (seq_busy),
    .cnt     (seq_cnt),
    .mask    (seq_mask),
    .done    (seq_done)
  );

  // access permissions
  assign open = acc_en && !seq_busy && !standby_q;
  assign rd_perm[BK_FAST]  = ctrl_q.fast_en;
  assign rd_perm[BK_LARGE] = ctrl_q.large_en;
  assign rd_perm[BK_RET]   = ctrl_q.large_en;
  assign wr_perm[BK_FAST]  = ctrl_q.fast_en & ctrl_q.fast_we;
  assign wr_perm[BK_LARGE] = ctrl_q.large_en & ctrl_q.large_we;
  assign wr_perm[BK_RET]   = ctrl_q.large_en & ctrl_q.large_we & ctrl_q.ret_we;

  always_comb begin
    rd_ok = 1'b0;
    for (int b = 0; b < NBANK; b++)
      if (acc_bank == 2'(b) && rd_perm[b]) rd_ok = open && !acc_we;
  end

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      localparam int BAW = (b == BK_FAST) ? FAST_AW : ((b == BK_LARGE) ? LARGE_AW : RET_AW);
      logic [BAW-1:0] addr;
      logic           we;
      logic [DW-1:0]  wd;

      assign wr_ok[b] = open && acc_we && (acc_bank == 2'(b)) && wr_perm[b];

      always_comb begin
        if (seq_busy) begin
          addr = seq_cnt[BAW-1:0];
          we   = seq_mask[b] && (int'(seq_cnt) < (1 << BAW));
          wd   = POISON_W;
        end else begin
          addr = acc_addr[BAW-1:0];
          we   = wr_ok[b];
          wd   = acc_wdata;
        end
      end

      rr_ram_bank #(.DW(DW), .AW(BAW)) u_mem (
        .clk   (clk),
        .we    (we),
        .addr  (addr),
        .wdata (wd),
        .q     (bank_q[b])
      );

      p_no_user_write_standby_r9: assert property (@(posedge clk) disable iff (rst)
        (standby_q && !seq_busy) |-> !we);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ok_q <= 1'b0;
      sel_q   <= '0;
    end else begin
      rd_ok_q <= rd_ok;
      sel_q   <= acc_bank;
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (rd_ok_q) begin
      case (sel_q)
        2'd0:    acc_rdata = bank_q[BK_FAST];
        2'd1:    acc_rdata = bank_q[BK_LARGE];
        2'd2:    acc_rdata = bank_q[BK_RET];
        default: acc_rdata = '0;
      endcase
    end
  end

  // control, status and standby state
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      status_q  <= '0;
      standby_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      if (reg_we && !reg_addr && !seq_busy) ctrl_q <= ctrl_t'(reg_wdata);
      if (evt_valid) begin
        status_q <= keep_flags;
        pend_q   <= ctl_rst;
        if (evt_code == EV_ENTER) standby_q <= 1'b1;
        else if (evt_code == EV_EXIT_RST || evt_code == EV_EXIT_WAKE) standby_q <= 1'b0;
      end
      if (seq_done && pend_q) begin
        ctrl_q <= '0;
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= reg_addr ? {1'b0, standby_q, seq_busy, status_q} : 6'(ctrl_q);
  end

  p_ctrl_hold_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && $past(seq_busy)) |-> $stable(ctrl_q));
  p_ctrl_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(seq_busy) && $past(pend_q)) |-> (ctrl_q == '0));
  p_entry_status_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(standby_q) |-> (status_q[BK_LARGE:BK_FAST] == 2'b00));
  p_idle_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(acc_en) |-> (acc_rdata == '0));
  p_standby_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    $past(standby_q) |-> (acc_rdata == '0));
endmodule

// File: tb/ram_retention_ctrl_test.sv
module ram_retention_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 0, reg_addr = 0;
  logic [5:0] reg_wdata = 0, reg_rdata;
  logic por_evt = 0, dstby_enter = 0, dstby_exit = 0;
  logic [1:0] wake_cause = 0;
  logic acc_en = 0, acc_we = 0;
  logic [1:0] acc_bank = 0;
  logic [3:0] acc_addr = 0;
  logic [7:0] acc_wdata = 0, acc_rdata;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ram_retention_ctrl uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .por_evt(por_evt),
    .dstby_enter(dstby_enter), .dstby_exit(dstby_exit), .wake_cause(wake_cause),
    .acc_en(acc_en), .acc_we(acc_we), .acc_bank(acc_bank), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata)
  );

  function automatic int depth_of(int b);
    return (b == 0) ? 8 : ((b == 1) ? 16 : 4);
  endfunction

  function automatic logic [7:0] pat(int b, int a, int s);
    return 8'((b * 37 + a * 11 + s * 5 + 1) & 255);
  endfunction

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic reg_write(logic a, logic [5:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_read(logic a, output logic [5:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic mem_write(int b, int a, logic [7:0] d);
    acc_en = 1; acc_we = 1; acc_bank = 2'(b); acc_addr = 4'(a); acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_we = 0;
  endtask

  task automatic mem_read(int b, int a, output logic [7:0] d);
    acc_en = 1; acc_we = 0; acc_bank = 2'(b); acc_addr = 4'(a);
    @(negedge clk);
    d = acc_rdata;
    acc_en = 0;
  endtask

  task automatic wait_idle(output int n);
    logic [5:0] d;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      reg_read(1'b1, d);
      if (!d[3]) break;
      n++;
    end
  endtask

  task automatic fill(int s);
    reg_write(1'b0, 6'h1F);
    for (int b = 0; b < 3; b++)
      for (int a = 0; a < depth_of(b); a++) mem_write(b, a, pat(b, a, s));
  endtask

  task automatic check_bank(string req, int b, bit wiped, int s);
    logic [7:0] d;
    for (int a = 0; a < depth_of(b); a++) begin
      mem_read(b, a, d);
      check(req, d, wiped ? 8'hA5 : pat(b, a, s));
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [5:0] r;
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R10 reset state
    reg_read(1'b0, r); check("R10 ctrl after reset", r, 0);
    reg_read(1'b1, r); check("R10 status after reset", r, 0);
    check("R8 rdata idle", acc_rdata, 0);

    // R1 R2 R3 R6 R10: POR sweep over five enable bits
    for (int c = 0; c < 32; c++) begin
      bit cf, cl, cr;
      fill(c);
      reg_write(1'b0, 6'(c));
      cf = c[0] & c[1];
      cl = c[2] & c[3];
      cr = c[2] & c[3] & c[4];
      por_evt = 1; @(negedge clk); por_evt = 0;
      wait_idle(n);
      check("R6 busy cycles", n, 16);
      reg_read(1'b1, r); check("R10 status after por", r, {3'b000, ~cr, ~cl, ~cf});
      reg_read(1'b0, r); check("R7 ctrl zero after por", r, 0);
      reg_write(1'b0, 6'h1F);
      check_bank("R1 fast bank", 0, cf, c);
      check_bank("R2 large bank", 1, cl, c);
      check_bank("R3 retention bank", 2, cr, c);
    end

    // R4 R5: standby, keep x exit cause, plus reset pulse in standby
    for (int k = 0; k < 2; k++) begin
      for (int m = 0; m < 4; m++) begin
        bit ret_ok;
        int s;
        s = 40 + k * 4 + m;
        fill(s);
        reg_write(1'b0, 6'h1F | 6'(k << 5));
        dstby_enter = 1; @(negedge clk); dstby_enter = 0;
        wait_idle(n);
        check("R6 busy cycles entry", n, 16);
        reg_read(1'b1, r); check("R4 status in standby", r, {2'b01, 1'b0, 1'(k), 2'b00});
        mem_read(2, 1, d); check("R9 read in standby", d, 0);
        mem_write(2, 1, 8'h3C);
        if (m == 3) begin
          por_evt = 1; @(negedge clk); por_evt = 0;
          ret_ok = 0;
        end else begin
          wake_cause = 2'(m);
          dstby_exit = 1; @(negedge clk); dstby_exit = 0;
          ret_ok = (k == 1) && (m != 0);
        end
        wait_idle(n);
        reg_read(1'b1, r); check("R5 status after exit", r, {3'b000, ret_ok, 2'b00});
        reg_read(1'b0, r); check("R5 ctrl zero after exit", r, 0);
        reg_write(1'b0, 6'h1F);
        check_bank("R4 fast after standby", 0, 1, s);
        check_bank("R4 large after standby", 1, 1, s);
        check_bank("R5 retention after exit", 2, !ret_ok, s);
      end
    end

    // R8 permission gates
    fill(60);
    reg_write(1'b0, 6'h1E);
    mem_read(0, 2, d); check("R8 fast read without enable", d, 0);
    reg_write(1'b0, 6'h1D);
    mem_write(0, 2, 8'h11);
    reg_write(1'b0, 6'h1B);
    mem_read(1, 3, d); check("R8 large read without enable", d, 0);
    mem_read(2, 3, d); check("R8 retention read without large enable", d, 0);
    reg_write(1'b0, 6'h17);
    mem_write(1, 3, 8'h22);
    reg_write(1'b0, 6'h0F);
    mem_write(2, 3, 8'h33);
    mem_write(1, 4, 8'h44);
    reg_write(1'b0, 6'h1F);
    mem_read(0, 2, d); check("R8 fast write refused", d, pat(0, 2, 60));
    mem_read(1, 3, d); check("R8 large write refused", d, pat(1, 3, 60));
    mem_read(2, 3, d); check("R8 retention write refused", d, pat(2, 3, 60));
    mem_read(1, 4, d); check("R8 large write allowed", d, 8'h44);

    // R7 R9: frozen control and closed port during a sweep
    reg_write(1'b0, 6'h15);
    por_evt = 1; @(negedge clk); por_evt = 0;
    mem_write(0, 5, 8'h77);
    mem_read(0, 5, d); check("R9 read while busy", d, 0);
    reg_write(1'b0, 6'h3F);
    reg_read(1'b0, r); check("R7 ctrl frozen while busy", r, 6'h15);
    wait_idle(n);
    reg_read(1'b0, r); check("R7 ctrl zero after sweep", r, 0);
    reg_read(1'b1, r); check("R10 status nothing wiped", r, 6'h07);
    reg_write(1'b0, 6'h1F);
    mem_read(0, 5, d); check("R9 write while busy refused", d, pat(0, 5, 60));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule